// File: doc/BRIEF.md
# Ring Command/Result Node

This block is the per-node attachment point on a one-way ring that links a single central controller with a set of peripheral nodes. Traffic on the ring is a stream of 8-bit flits, grouped into packets. Only the controller starts packets. Each packet opens with a header flit that gives its kind (command or empty), a node number and its payload length. The payload flits follow directly behind the header.

A node inspects each packet as it passes. A command addressed to this node is pulled off the ring and its payload appears on a local command port. In its place the node forwards an empty packet of the same length, so the timing of the ring is unchanged. An empty packet that arrives while the node holds enough queued result bytes to fill it is turned into a result packet: the header is rewritten with this node's number and the payload is replaced by queued bytes. Every other flit goes through unchanged. Peripheral nodes therefore never start traffic. They answer only inside capacity that the controller has sent round the ring.

Top module: `ring_node`

## Requirements
- R1: After reset `out_valid` and `cmd_valid` are 0, `in_ready` is 1, and `res_ready` is 1 (result queue empty).
- R2: Header flit encoding is: bit 7 is the kind (1 = command, 0 = empty), bits 6:3 are the node number, and bits 2:0 are the payload length minus one. A command packet whose node number differs from `NODE_ID` leaves the node unchanged, header and payload alike.
- R3: The payload of a command packet addressed to `NODE_ID` appears on `cmd_byte` in arrival order, one `cmd_valid` pulse per byte. `cmd_last` is 1 on the final byte only. Each command is delivered exactly once.
- R4: A command packet that the node takes is replaced on the ring by an empty packet of the same length. Its header is 0x00 with the length field copied, and every payload flit is 0x00.
- R5: An empty packet of length L is filled only when the result queue holds at least L bytes. The header then becomes kind 1, node number `NODE_ID`, same length field, and the payload flits are the L oldest queued bytes in push order.
- R6: An empty packet that arrives while the queue holds fewer bytes than its length leaves the node unchanged, header and payload alike.
- R7: Each node adds exactly one register stage. A flit accepted on an edge is presented on `out_flit` right after that edge, and `in_ready` equals `!out_valid || out_ready`.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_flit` hold. No flit is lost or duplicated under backpressure.
- R9: The result queue holds `RESQ_DEPTH` bytes. `res_ready` is 0 when the queue is full, and a byte offered while the queue is full is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Ring clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Upstream flit valid |
| in_flit | input | 8 | Upstream flit |
| in_ready | output | 1 | Node can accept an upstream flit |
| out_valid | output | 1 | Downstream flit valid |
| out_flit | output | 8 | Downstream flit |
| out_ready | input | 1 | Downstream can accept |
| cmd_valid | output | 1 | Command byte strobe |
| cmd_byte | output | 8 | Command payload byte |
| cmd_last | output | 1 | Final byte of the command |
| res_valid | input | 1 | Local result byte offered |
| res_byte | input | 8 | Local result byte |
| res_ready | output | 1 | Result queue can take a byte |

## Verification
The bench builds a ring of four nodes with numbers 1 to 4 and the default queue depth of 8. That depth equals the largest packet length, so one packet can drain a full queue. The bench sweeps every node number against every payload length from 1 to 8, for commands and for result fills. For each fill it first offers one byte too few and then exactly enough. It also covers priority between nodes that are both ready to fill, a full queue that refuses a further byte, and headers addressed to no node. A pseudo-random stall on the controller's receive side exercises backpressure in every sweep. A stall-free run then measures the four-stage latency around the ring.

// File: rtl/ring_pkg.sv
package ring_pkg;
  localparam int FLIT_W = 8;
  localparam int ID_W   = 4;
  localparam int LEN_W  = 3;
  localparam int CNT_W  = LEN_W + 1;

  typedef enum logic [1:0] {M_PASS, M_TAKE, M_FILL} fwd_mode_e;

  // header: [7] kind, [6:3] node number, [2:0] length-1
  function automatic logic [FLIT_W-1:0] make_hdr(input logic is_cmd,
                                                 input logic [ID_W-1:0] node,
                                                 input logic [LEN_W-1:0] len_m1);
    return {is_cmd, node, len_m1};
  endfunction

  function automatic logic hdr_is_cmd(input logic [FLIT_W-1:0] h);
    return h[FLIT_W-1];
  endfunction

  function automatic logic [ID_W-1:0] hdr_node(input logic [FLIT_W-1:0] h);
    return h[LEN_W +: ID_W];
  endfunction

  function automatic logic [CNT_W-1:0] hdr_len(input logic [FLIT_W-1:0] h);
    return {1'b0, h[LEN_W-1:0]} + CNT_W'(1);
  endfunction
endpackage

// File: rtl/ring_resq.sv
module ring_resq #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int QC_W  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [W-1:0]    din,
  input  logic            pop,
  output logic [W-1:0]    dout,
  output logic [QC_W-1:0] count,
  output logic            full,
  output logic            empty
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full  = (count == QC_W'(DEPTH));
  assign empty = (count == '0);
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + QC_W'(1);
        2'b01:   count <= count - QC_W'(1);
        default: count <= count;
      endcase
    end
  end

  // fill logic must never draw from an empty queue
  assert_pop_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= QC_W'(DEPTH));
endmodule

// File: rtl/ring_pkt_track.sv
module ring_pkt_track
  import ring_pkg::*;
#(
  parameter int NODE_ID = 1,
  parameter int QC_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [FLIT_W-1:0] flit,
  input  logic [QC_W-1:0]   q_count,
  output logic              at_hdr,
  output logic              hdr_take,
  output logic              hdr_fill,
  output logic              byte_take,
  output logic              byte_fill,
  output logic              byte_last
);
  logic [CNT_W-1:0] remain;
  fwd_mode_e        mode_q;
  logic [CNT_W-1:0] len;

  assign len      = hdr_len(flit);
  assign at_hdr   = (remain == '0);
  assign hdr_take = at_hdr && hdr_is_cmd(flit) && (hdr_node(flit) == ID_W'(NODE_ID));
  assign hdr_fill = at_hdr && !hdr_is_cmd(flit) && (int'(q_count) >= int'(len));
  assign byte_take = !at_hdr && (mode_q == M_TAKE);
  assign byte_fill = !at_hdr && (mode_q == M_FILL);
  assign byte_last = !at_hdr && (remain == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
      mode_q <= M_PASS;
    end else if (fire) begin
      if (at_hdr) begin
        remain <= len;
        mode_q <= hdr_take ? M_TAKE : (hdr_fill ? M_FILL : M_PASS);
      end else begin
        remain <= remain - CNT_W'(1);
      end
    end
  end

  assert_len_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    remain <= CNT_W'(1 << LEN_W));
  assert_mode_idle_at_hdr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && byte_last) |=> at_hdr);
endmodule

// File: rtl/ring_node.sv
module ring_node
  import ring_pkg::*;
#(
  parameter int NODE_ID    = 1,
  parameter int RESQ_DEPTH = 8,
  localparam int QC_W = $clog2(RESQ_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [FLIT_W-1:0] in_flit,
  output logic              in_ready,
  output logic              out_valid,
  output logic [FLIT_W-1:0] out_flit,
  input  logic              out_ready,
  output logic              cmd_valid,
  output logic [FLIT_W-1:0] cmd_byte,
  output logic              cmd_last,
  input  logic              res_valid,
  input  logic [FLIT_W-1:0] res_byte,
  output logic              res_ready
);
  logic              fire;
  logic              at_hdr, hdr_take, hdr_fill, byte_take, byte_fill, byte_last;
  logic              q_push, q_pop, q_full, q_empty;
  logic [FLIT_W-1:0] q_head;
  logic [QC_W-1:0]   q_count;
  logic [FLIT_W-1:0] nxt_flit;

  assign in_ready  = !out_valid || out_ready;
  assign fire      = in_valid && in_ready;
  assign res_ready = !q_full;
  assign q_push    = res_valid && !q_full;
  assign q_pop     = fire && byte_fill;

  ring_resq #(.DEPTH(RESQ_DEPTH), .W(FLIT_W)) u_resq (
    .clk(clk), .rst_n(rst_n), .push(q_push), .din(res_byte), .pop(q_pop),
    .dout(q_head), .count(q_count), .full(q_full), .empty(q_empty)
  );

  ring_pkt_track #(.NODE_ID(NODE_ID), .QC_W(QC_W)) u_track (
    .clk(clk), .rst_n(rst_n), .fire(fire), .flit(in_flit), .q_count(q_count),
    .at_hdr(at_hdr), .hdr_take(hdr_take), .hdr_fill(hdr_fill),
    .byte_take(byte_take), .byte_fill(byte_fill), .byte_last(byte_last)
  );

  always_comb begin
    if (hdr_take)       nxt_flit = make_hdr(1'b0, '0, in_flit[LEN_W-1:0]);
    else if (hdr_fill)  nxt_flit = make_hdr(1'b1, ID_W'(NODE_ID), in_flit[LEN_W-1:0]);
    else if (byte_take) nxt_flit = '0;
    else if (byte_fill) nxt_flit = q_head;
    else                nxt_flit = in_flit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_flit  <= '0;
      cmd_valid <= 1'b0;
      cmd_byte  <= '0;
      cmd_last  <= 1'b0;
    end else begin
      if (fire) begin
        out_valid <= 1'b1;
        out_flit  <= nxt_flit;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      cmd_valid <= fire && byte_take;
      cmd_last  <= fire && byte_take && byte_last;
      if (fire && byte_take) cmd_byte <= in_flit;
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_flit)));
  assert_one_stage_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);
  assert_last_in_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_last |-> cmd_valid);
  assert_cmd_from_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(fire));
  assert_fill_one_kind_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(hdr_take && hdr_fill) && !(byte_take && byte_fill));
  assert_full_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full && !q_pop) |=> q_full);
endmodule

// File: tb/ring_node_tb.sv
module ring_node_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NODES = 4;
  localparam int DEPTH = 8;

  logic clk = 0;
  logic rst_n = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       ctl_valid = 0;
  logic [7:0] ctl_flit = 0;
  logic       ctl_ready = 1;
  logic       steady = 1;
  logic [7:0] lfsr = 8'h5B;
  int         cyc = 0;

  logic       lv [0:NODES];
  logic       lr [0:NODES];
  logic [7:0] lf [0:NODES];
  logic       cv [NODES];
  logic       cl [NODES];
  logic [7:0] cb [NODES];
  logic       rv [NODES];
  logic [7:0] rb [NODES];
  logic       rr [NODES];

  assign lv[0] = ctl_valid;
  assign lf[0] = ctl_flit;
  assign lr[NODES] = ctl_ready;

  for (genvar g = 0; g < NODES; g++) begin : g_ring
    ring_node #(.NODE_ID(g + 1), .RESQ_DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(lv[g]), .in_flit(lf[g]), .in_ready(lr[g]),
      .out_valid(lv[g+1]), .out_flit(lf[g+1]), .out_ready(lr[g+1]),
      .cmd_valid(cv[g]), .cmd_byte(cb[g]), .cmd_last(cl[g]),
      .res_valid(rv[g]), .res_byte(rb[g]), .res_ready(rr[g])
    );
  end

  int tests = 0, fails = 0;
  logic [7:0] rx_q [0:63];
  int rx_n = 0, rx_stamp = 0, tx_stamp = 0;
  logic [7:0] cq [NODES][0:15];
  int cn [NODES];
  int cl_cnt [NODES];
  int cl_pos [NODES];
  logic [7:0] tx_pay [0:7];
  logic [7:0] exp_pay [0:7];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    ctl_ready <= steady ? 1'b1 : (lfsr[1] | lfsr[4]);
  end

  always @(negedge clk) begin
    #1;
    if (lv[NODES] && ctl_ready) begin
      if (rx_n == 0) rx_stamp = cyc;
      if (rx_n < 64) rx_q[rx_n] = lf[NODES];
      rx_n++;
    end
    for (int i = 0; i < NODES; i++) begin
      if (cv[i]) begin
        if (cn[i] < 16) cq[i][cn[i]] = cb[i];
        if (cl[i]) begin cl_cnt[i]++; cl_pos[i] = cn[i]; end
        cn[i]++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] hdr(input bit k, input int node, input int len);
    return {k, node[3:0], 3'(len - 1)};
  endfunction

  task automatic send_flit(input logic [7:0] b);
    @(negedge clk); #2;
    ctl_valid = 1; ctl_flit = b;
    while (!lr[0]) begin @(negedge clk); #2; end
    @(posedge clk); #1;
    tx_stamp = cyc;
    ctl_valid = 0;
  endtask

  task automatic clear_mon();
    rx_n = 0;
    for (int i = 0; i < NODES; i++) begin cn[i] = 0; cl_cnt[i] = 0; cl_pos[i] = -1; end
  endtask

  task automatic send_pkt(input logic [7:0] h, input int len);
    clear_mon();
    send_flit(h);
    for (int i = 0; i < len; i++) send_flit(tx_pay[i]);
    for (int t = 0; t < 300 && rx_n < len + 1; t++) @(negedge clk);
    repeat (3) @(negedge clk);
    check(rx_n == len + 1, "R8 flit count", rx_n, len + 1);
  endtask

  task automatic push_res(input int n, input logic [7:0] b);
    @(negedge clk); #2;
    rv[n] = 1; rb[n] = b;
    while (!rr[n]) begin @(negedge clk); #2; end
    @(posedge clk); #1;
    rv[n] = 0;
  endtask

  task automatic check_pay(input string req, input int len);
    bit ok = 1;
    int bad = 0, want = 0;
    for (int i = 0; i < len; i++)
      if (rx_q[i+1] !== exp_pay[i]) begin
        if (ok) begin bad = rx_q[i+1]; want = exp_pay[i]; end
        ok = 0;
      end
    check(ok, req, bad, want);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NODES; i++) begin rv[i] = 0; rb[i] = 0; end
    clear_mon();
    repeat (3) @(negedge clk);
    #2;
    // R1 reset state
    check(lv[NODES] == 0 && lv[1] == 0, "R1 out_valid", lv[NODES], 0);
    check(lr[0] == 1, "R1 in_ready", lr[0], 1);
    check(cv[0] == 0 && cv[1] == 0 && cv[2] == 0 && cv[3] == 0, "R1 cmd_valid", cv[0], 0);
    check(rr[0] && rr[1] && rr[2] && rr[3], "R1 res_ready", rr[0], 1);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R7 latency: one stage per node with no stall
    steady = 1;
    for (int i = 0; i < 8; i++) tx_pay[i] = 8'(i);
    clear_mon();
    send_flit(hdr(1, 12, 1));
    for (int t = 0; t < 50 && rx_n < 1; t++) @(negedge clk);
    check(rx_stamp - tx_stamp == NODES - 1, "R7 ring latency", rx_stamp - tx_stamp, NODES - 1);
    send_flit(tx_pay[0]);
    repeat (8) @(negedge clk);
    check(lr[0] == 1, "R7 in_ready idle", lr[0], 1);

    steady = 0;
    // R3 / R4 command sweep, all nodes, all lengths, under backpressure
    for (int n = 0; n < NODES; n++) begin
      for (int len = 1; len <= 8; len++) begin
        bit ok = 1;
        for (int i = 0; i < len; i++) tx_pay[i] = 8'(n * 37 + len * 11 + i * 5 + 1);
        send_pkt(hdr(1, n + 1, len), len);
        check(rx_q[0] == hdr(0, 0, len), "R4 replacement header", rx_q[0], hdr(0, 0, len));
        for (int i = 0; i < len; i++) exp_pay[i] = 8'h00;
        check_pay("R4 replacement payload", len);
        check(cn[n] == len, "R3 cmd byte count", cn[n], len);
        for (int i = 0; i < len; i++) if (cq[n][i] !== tx_pay[i]) ok = 0;
        check(ok, "R3 cmd byte order", cq[n][0], tx_pay[0]);
        check(cl_cnt[n] == 1 && cl_pos[n] == len - 1, "R3 cmd_last", cl_pos[n], len - 1);
        for (int o = 0; o < NODES; o++)
          if (o != n) check(cn[o] == 0, "R3 exactly once", cn[o], 0);
      end
    end

    // R2 commands for absent node numbers pass unchanged
    for (int id = 0; id < 16; id += 9) begin
      for (int i = 0; i < 5; i++) tx_pay[i] = 8'(8'hA0 + i * 3 + id);
      send_pkt(hdr(1, id, 5), 5);
      check(rx_q[0] == hdr(1, id, 5), "R2 header unchanged", rx_q[0], hdr(1, id, 5));
      for (int i = 0; i < 5; i++) exp_pay[i] = tx_pay[i];
      check_pay("R2 payload unchanged", 5);
      check(cn[0] + cn[1] + cn[2] + cn[3] == 0, "R2 no delivery", cn[0], 0);
    end

    // R5 / R6 fill sweep
    for (int n = 0; n < NODES; n++) begin
      for (int len = 1; len <= 8; len++) begin
        for (int k = 0; k < len - 1; k++) push_res(n, 8'(n * 50 + len * 7 + k));
        for (int i = 0; i < len; i++) tx_pay[i] = 8'(8'hC0 + i);
        send_pkt(hdr(0, 0, len), len);
        check(rx_q[0] == hdr(0, 0, len), "R6 short queue header", rx_q[0], hdr(0, 0, len));
        for (int i = 0; i < len; i++) exp_pay[i] = tx_pay[i];
        check_pay("R6 short queue payload", len);
        push_res(n, 8'(n * 50 + len * 7 + len - 1));
        send_pkt(hdr(0, 0, len), len);
        check(rx_q[0] == hdr(1, n + 1, len), "R5 filled header", rx_q[0], hdr(1, n + 1, len));
        for (int i = 0; i < len; i++) exp_pay[i] = 8'(n * 50 + len * 7 + i);
        check_pay("R5 filled payload order", len);
      end
    end

    // R5 upstream node fills first, the other later
    for (int k = 0; k < 2; k++) begin push_res(0, 8'(8'h10 + k)); push_res(2, 8'(8'h30 + k)); end
    for (int i = 0; i < 2; i++) tx_pay[i] = 8'h77;
    send_pkt(hdr(0, 0, 2), 2);
    check(rx_q[0] == hdr(1, 1, 2), "R5 upstream first", rx_q[0], hdr(1, 1, 2));
    exp_pay[0] = 8'h10; exp_pay[1] = 8'h11;
    check_pay("R5 upstream bytes", 2);
    send_pkt(hdr(0, 0, 2), 2);
    check(rx_q[0] == hdr(1, 3, 2), "R5 downstream next", rx_q[0], hdr(1, 3, 2));
    exp_pay[0] = 8'h30; exp_pay[1] = 8'h31;
    check_pay("R5 downstream bytes", 2);

    // R9 full queue refuses more
    for (int k = 0; k < DEPTH; k++) push_res(1, 8'(8'h60 + k));
    @(negedge clk); #2;
    check(rr[1] == 0, "R9 res_ready when full", rr[1], 0);
    rv[1] = 1; rb[1] = 8'hEE;
    repeat (3) @(negedge clk);
    #2; rv[1] = 0;
    for (int i = 0; i < 8; i++) tx_pay[i] = 8'h00;
    send_pkt(hdr(0, 0, 8), 8);
    check(rx_q[0] == hdr(1, 2, 8), "R9 drain header", rx_q[0], hdr(1, 2, 8));
    for (int i = 0; i < 8; i++) exp_pay[i] = 8'(8'h60 + i);
    check_pay("R9 extra byte dropped", 8);
    @(negedge clk); #2;
    check(rr[1] == 1, "R9 res_ready after drain", rr[1], 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule